// File: doc/BRIEF.md
# Per-CPU Device Interrupt Mask Router

The router receives one shared vector of raw device interrupt requests and spreads it to up to four processors. Each processor owns a private 64-bit enable mask. The block keeps a masked-request register per processor, which is the AND of that mask with the shared raw vector. It drives one level-sensitive device interrupt line per processor. That line is high while any bit of the processor's masked-request register is set.

The line is re-evaluated whenever a mask is written and whenever the raw vector changes. Setting a mask bit whose raw request is active raises the line. Clearing the last contributing mask bit, or losing the raw request behind it, drops the line.

Configuration uses a simple register bus. A request carries a write flag, an access size, a byte address and 64-bit write data. One cycle later the block returns a response pulse with read data and an error flag. Registers sit on a 64-byte stride, and only full 64-bit accesses are accepted.

Top module: `irq_mask_router`

## Requirements
- R1: Register index `c` (byte address `c*64`, `c` from 0 to 3) is the read/write mask of processor `c`. A legal write replaces only that mask, and a read returns the stored value.
- R2: Register index `4+c` returns processor `c`'s masked request, equal to its mask AND the raw vector. It reflects a mask write or a raw-vector change from the clock edge that samples it.
- R3: `dev_irq_o[c]` is high exactly when processor `c`'s masked request is nonzero. Enabling a mask bit whose raw request is set raises the line at the edge that takes the write, and clearing the mask or the raw bit lowers it at the next edge.
- R4: Register index 8 returns the raw request vector as sampled at the most recent clock edge.
- R5: The register index is the byte address shifted right by 6. Address bits 5:0 do not affect which register is accessed.
- R6: `size_i` encodes log2 of the access bytes (0=1, 1=2, 2=4, 3=8). Any size other than 3 raises the error flag, returns zero data and leaves every mask unchanged.
- R7: A write to a masked-request register (index 4 to 7) or to the raw register (index 8) raises the error flag and changes no mask.
- R8: An access to index 9 or above raises the error flag, returns zero data and changes no mask.
- R9: After reset all masks are zero, every interrupt line is low and no response is pending.
- R10: Each request produces exactly one `rvalid_o` pulse in the following cycle. Its read data is the register contents before the edge that takes the request, and a write returns zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus request valid for one cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | Access size, log2 of bytes |
| addr_i | input | 10 | Byte address |
| wdata_i | input | 64 | Write data |
| raw_irq_i | input | 64 | Shared raw device request vector |
| rvalid_o | output | 1 | Response valid, one cycle after request |
| rdata_o | output | 64 | Read data |
| err_o | output | 1 | Access error flag, valid with rvalid_o |
| dev_irq_o | output | 4 | Per-processor device interrupt line |

## Verification
A mask write takes effect at the clock edge that samples the request. The mask, the masked request and the interrupt line all change there, and the bus response appears after that same edge. A raw-vector change shows in the raw view, the masked requests and the lines after exactly one edge. The bench drives inputs on falling edges and pushes the expected response of every bus operation into a queue. A monitor pops that queue and compares on the falling edge where `rvalid_o` is high. Line checks are made on the first falling edge after the stimulating edge, so each result is sampled in the cycle it is due.

// File: rtl/irq_rt_pkg.sv
package irq_rt_pkg;
  localparam int unsigned STRIDE_LSB = 6;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2,
    SZ_D = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    K_NONE   = 2'd0,
    K_MASK   = 2'd1,
    K_MASKED = 2'd2,
    K_RAW    = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/irq_rt_decode.sv
module irq_rt_decode
  import irq_rt_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned IDX_W   = 4,
  localparam int unsigned LANE_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               req_i,
  input  logic               we_i,
  input  logic [1:0]         size_i,
  input  logic [IDX_W-1:0]   idx_i,
  output reg_kind_e          kind_o,
  output logic [LANE_W-1:0]  lane_o,
  output logic               bad_o,
  output logic [NUM_CPU-1:0] mask_we_o
);
  logic [31:0] idx_n;

  always_comb begin
    idx_n  = 32'(idx_i);
    kind_o = K_NONE;
    lane_o = '0;
    if (idx_n < NUM_CPU) begin
      kind_o = K_MASK;
      lane_o = LANE_W'(idx_n);
    end else if (idx_n < 2 * NUM_CPU) begin
      kind_o = K_MASKED;
      lane_o = LANE_W'(idx_n - NUM_CPU);
    end else if (idx_n == 2 * NUM_CPU) begin
      kind_o = K_RAW;
    end
    bad_o = (size_i != SZ_D) || (kind_o == K_NONE) || (we_i && kind_o != K_MASK);
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_we
    assign mask_we_o[c] = req_i && we_i && !bad_o && (kind_o == K_MASK)
                          && (lane_o == LANE_W'(c));
  end
endmodule

// File: rtl/irq_rt_lane.sv
module irq_rt_lane #(
  parameter int unsigned DW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] raw_i,
  output logic [DW-1:0] mask_o,
  output logic [DW-1:0] masked_o,
  output logic          irq_o
);
  logic [DW-1:0] mask_q, masked_q, mask_d, masked_d;
  logic          irq_q;

  always_comb begin
    mask_d   = wr_en_i ? wdata_i : mask_q;
    masked_d = mask_d & raw_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q   <= '0;
      masked_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      mask_q   <= mask_d;
      masked_q <= masked_d;
      irq_q    <= |masked_d;
    end
  end

  assign mask_o   = mask_q;
  assign masked_o = masked_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/irq_mask_router.sv
module irq_mask_router
  import irq_rt_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned DW      = 64,
  parameter int unsigned ADDR_W  = 10,
  localparam int unsigned IDX_W  = ADDR_W - STRIDE_LSB,
  localparam int unsigned LANE_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [1:0]         size_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic [DW-1:0]      raw_irq_i,
  output logic               rvalid_o,
  output logic [DW-1:0]      rdata_o,
  output logic               err_o,
  output logic [NUM_CPU-1:0] dev_irq_o
);
  reg_kind_e          kind;
  logic [LANE_W-1:0]  lane;
  logic               bad;
  logic [NUM_CPU-1:0] mask_we;
  logic [DW-1:0]      raw_q, rd_d;
  logic [DW-1:0]      mask_a   [NUM_CPU];
  logic [DW-1:0]      masked_a [NUM_CPU];
  logic [NUM_CPU*DW-1:0] mask_flat, masked_flat;
  logic               rvalid_q, err_q;
  logic [DW-1:0]      rdata_q;
  logic               unused_lsb;

  assign unused_lsb = ^addr_i[STRIDE_LSB-1:0];

  irq_rt_decode #(.NUM_CPU(NUM_CPU), .IDX_W(IDX_W)) u_dec (
    .req_i     (req_i),
    .we_i      (we_i),
    .size_i    (size_i),
    .idx_i     (addr_i[ADDR_W-1:STRIDE_LSB]),
    .kind_o    (kind),
    .lane_o    (lane),
    .bad_o     (bad),
    .mask_we_o (mask_we)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_lane
    irq_rt_lane #(.DW(DW)) u_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (mask_we[c]),
      .wdata_i  (wdata_i),
      .raw_i    (raw_irq_i),
      .mask_o   (mask_a[c]),
      .masked_o (masked_a[c]),
      .irq_o    (dev_irq_o[c])
    );
    assign mask_flat[c*DW +: DW]   = mask_a[c];
    assign masked_flat[c*DW +: DW] = masked_a[c];
  end

  always_comb begin
    rd_d = '0;
    if (!we_i && !bad) begin
      unique case (kind)
        K_MASK:   rd_d = mask_a[lane];
        K_MASKED: rd_d = masked_a[lane];
        K_RAW:    rd_d = raw_q;
        default:  rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q    <= '0;
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
      rdata_q  <= '0;
    end else begin
      raw_q    <= raw_irq_i;
      rvalid_q <= req_i;
      err_q    <= req_i && bad;
      rdata_q  <= req_i ? rd_d : '0;
    end
  end

  assign rvalid_o = rvalid_q;
  assign err_o    = err_q;
  assign rdata_o  = rdata_q;
endmodule

// File: rtl/irq_mask_router_chk.sv
module irq_mask_router_chk #(
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned DW      = 64,
  parameter int unsigned ADDR_W  = 10
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_i,
  input logic                  we_i,
  input logic [1:0]            size_i,
  input logic [ADDR_W-1:0]     addr_i,
  input logic                  rvalid_o,
  input logic                  err_o,
  input logic [NUM_CPU-1:0]    dev_irq_o,
  input logic [DW-1:0]         raw_q,
  input logic [NUM_CPU*DW-1:0] mask_flat,
  input logic [NUM_CPU*DW-1:0] masked_flat
);
  logic [31:0] idx;
  assign idx = 32'(addr_i >> 6);

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_c
    p_masked_and_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      masked_flat[c*DW +: DW] == (mask_flat[c*DW +: DW] & raw_q));
    p_line_or_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dev_irq_o[c] == (|masked_flat[c*DW +: DW]));
  end

  p_mask_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> $stable(mask_flat));
  p_size_err_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && size_i != 2'd3) |=> (err_o && $stable(mask_flat)));
  p_ro_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && idx >= NUM_CPU) |=> (err_o && $stable(mask_flat)));
  p_unmapped_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && idx > 2 * NUM_CPU) |=> err_o);
  p_resp_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rvalid_o);
  p_no_resp_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!rvalid_o && !err_o));
endmodule

bind irq_mask_router irq_mask_router_chk #(
  .NUM_CPU(NUM_CPU), .DW(DW), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .size_i      (size_i),
  .addr_i      (addr_i),
  .rvalid_o    (rvalid_o),
  .err_o       (err_o),
  .dev_irq_o   (dev_irq_o),
  .raw_q       (raw_q),
  .mask_flat   (mask_flat),
  .masked_flat (masked_flat)
);

// File: tb/sim_irq_mask_router.sv
module sim_irq_mask_router;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [1:0]  size_i = 2'd3;
  logic [9:0]  addr_i = '0;
  logic [63:0] wdata_i = '0;
  logic [63:0] raw_irq_i = '0;
  logic        rvalid_o, err_o;
  logic [63:0] rdata_o;
  logic [3:0]  dev_irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [63:0] rdata;
    logic        err;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  irq_mask_router u0 (.*);

  always #5 clk_i = ~clk_i;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // driver: push expectation, drive one request cycle
  task automatic bus_op(input bit we, input logic [1:0] sz, input logic [9:0] a,
                        input logic [63:0] wd, input logic [63:0] erd, input bit eerr,
                        input string tag);
    exp_t e;
    e.rdata = erd; e.err = eerr; e.tag = tag;
    exp_q.push_back(e);
    req_i = 1'b1; we_i = we; size_i = sz; addr_i = a; wdata_i = wd;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0; size_i = 2'd3;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk_i);
      if (rvalid_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R10 unexpected response", 64'(rvalid_o), 64'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(rdata_o == e.rdata, {e.tag, " rdata"}, rdata_o, e.rdata);
          check(err_o == e.err, {e.tag, " err"}, 64'(err_o), 64'(e.err));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      check(1'b0, "watchdog", 64'd0, 64'd1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(dev_irq_o == 4'h0, "R9 lines after reset", 64'(dev_irq_o), 64'd0);
    check(rvalid_o == 1'b0, "R9 no response in reset", 64'(rvalid_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(dev_irq_o == 4'h0, "R9 lines low", 64'(dev_irq_o), 64'd0);
    bus_op(0, 2'd3, 10'h0C0, '0, 64'd0, 0, "R9 mask3 zero");

    raw_irq_i = 64'h0000_00F0_0000_0001;
    @(negedge clk_i);
    bus_op(0, 2'd3, 10'h200, '0, 64'h0000_00F0_0000_0001, 0, "R4 raw view");

    bus_op(1, 2'd3, 10'h000, 64'h1, 64'd0, 0, "R1 write mask0");
    check(dev_irq_o == 4'b0001, "R3 line0 raised", 64'(dev_irq_o), 64'h1);
    bus_op(0, 2'd3, 10'h100, '0, 64'h1, 0, "R2 masked0");
    bus_op(1, 2'd3, 10'h040, 64'hF00, 64'd0, 0, "R1 write mask1");
    check(dev_irq_o == 4'b0001, "R3 line1 stays low", 64'(dev_irq_o), 64'h1);
    bus_op(1, 2'd3, 10'h080, 64'h0000_0010_0000_0000, 64'd0, 0, "R1 write mask2");
    check(dev_irq_o == 4'b0101, "R3 line2 raised", 64'(dev_irq_o), 64'h5);
    bus_op(0, 2'd3, 10'h07F, '0, 64'hF00, 0, "R5 low bits ignored");
    bus_op(0, 2'd3, 10'h000, '0, 64'h1, 0, "R1 mask0 readback");

    raw_irq_i = 64'h0;
    @(negedge clk_i);
    check(dev_irq_o == 4'b0000, "R3 lines follow raw drop", 64'(dev_irq_o), 64'h0);
    bus_op(0, 2'd3, 10'h180, '0, 64'h0, 0, "R2 masked2 after raw drop");

    raw_irq_i = 64'h0000_0000_0000_0300;
    @(negedge clk_i);
    check(dev_irq_o == 4'b0010, "R2 raw rise reaches line1", 64'(dev_irq_o), 64'h2);
    bus_op(0, 2'd3, 10'h140, '0, 64'h300, 0, "R2 masked1");
    bus_op(1, 2'd3, 10'h040, 64'h0, 64'd0, 0, "R3 clear mask1");
    check(dev_irq_o == 4'b0000, "R3 line1 dropped", 64'(dev_irq_o), 64'h0);

    bus_op(1, 2'd2, 10'h0C0, 64'hFFFF, 64'd0, 1, "R6 narrow write");
    bus_op(0, 2'd0, 10'h000, '0, 64'd0, 1, "R6 narrow read");
    bus_op(0, 2'd3, 10'h0C0, '0, 64'd0, 0, "R6 mask3 unchanged");

    bus_op(1, 2'd3, 10'h100, 64'hFF, 64'd0, 1, "R7 masked write");
    bus_op(1, 2'd3, 10'h200, 64'hFF, 64'd0, 1, "R7 raw write");
    bus_op(0, 2'd3, 10'h000, '0, 64'h1, 0, "R7 mask0 unchanged");

    bus_op(0, 2'd3, 10'h240, '0, 64'd0, 1, "R8 unmapped read");
    bus_op(1, 2'd3, 10'h3C0, 64'hFF, 64'd0, 1, "R8 unmapped write");
    bus_op(0, 2'd3, 10'h080, '0, 64'h0000_0010_0000_0000, 0, "R8 mask2 unchanged");
    check(dev_irq_o == 4'b0000, "R8 lines unchanged", 64'(dev_irq_o), 64'h0);

    // back-to-back: read returns value before the write edge of the next op
    bus_op(1, 2'd3, 10'h0C0, 64'h200, 64'd0, 0, "R10 write mask3");
    check(dev_irq_o == 4'b1000, "R3 line3 raised", 64'(dev_irq_o), 64'h8);
    bus_op(0, 2'd3, 10'h1C0, '0, 64'h200, 0, "R10 masked3 read");

    repeat (3) @(negedge clk_i);
    check(exp_q.size() == 0, "R10 all responses seen", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule